// File: doc/BRIEF.md
# Read-Sequence Store/Recall Command Detector

This block sits beside a memory-mapped SRAM and watches every access made to it. It spots a fixed unlock pattern made only of reads: five reads at fixed key addresses, in a fixed order, followed by a sixth read whose address chooses the command. One ending asks for the SRAM contents to be copied into the nonvolatile shadow (store). The other asks for the shadow to be copied back into the SRAM (recall). Any other ending asks for nothing.

Each access arrives as a one-cycle strobe. The strobe carries an address, a write flag, a flag that says whether the read was clocked by the chip enable, and the output-enable level. A write, or a read at an unexpected address, breaks the pattern, and no command comes out. While the transfer controller reports busy, the detector ignores every access and stays idle. A command leaves the block as a one-cycle pulse on the store or the recall output.

Top module: `nvseq_detector`

## Requirements
- R1: After synchronous reset, both request outputs are low and no steps of the pattern are held.
- R2: Enable-clocked reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, with no other access between them, raise store_req_o for exactly one cycle. The pulse comes in the cycle after the sixth strobe.
- R3: The same five reads followed by a read at 0x0C63 raise recall_req_o for exactly one cycle, with the same timing as R2.
- R4: Only address bits 13..0 are compared. The value of bit 14 never changes the result.
- R5: A write strobe aborts the pattern at any step, even when its address is the expected key. After the abort, the steps that remain produce no request.
- R6: An enable-clocked read at an address that is not the expected next key aborts the pattern. A sixth read at 0x339C produces neither request.
- R7: Reading the same key twice in a row (for example 0x31C7 twice) counts as an out-of-order access and aborts the pattern.
- R8: A mismatching read at 0x0E38 is not lost. It restarts the pattern as step one, so the next key expected is 0x31C7.
- R9: The output-enable level on a strobe does not affect recognition.
- R10: A read strobe that is not enable-clocked, and any cycle without a strobe, neither advances nor aborts the pattern.
- R11: While busy_i is high, strobes are ignored and the detector is forced idle. Pattern steps made before busy are discarded.
- R12: Store and recall requests are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Transfer controller busy; holds the detector idle |
| acc_valid_i | input | 1 | One-cycle access strobe |
| acc_addr_i | input | ADDR_W | Access address |
| acc_write_i | input | 1 | Strobe is a write |
| acc_ce_i | input | 1 | Read was clocked by the chip enable |
| acc_oe_i | input | 1 | Output-enable level (not used for recognition) |
| store_req_o | output | 1 | One-cycle store request |
| recall_req_o | output | 1 | One-cycle recall request |

## Verification
The bench builds the block with the default 15-bit address. This puts the ignored bit 14 within reach: the bench sets it on every step of a pattern and still expects the command. A behavioural model keeps a queue of accepted keys and is compared on every clock. Stimulus covers gaps between steps, strobes that are not enable-clocked in the middle of a pattern, busy inside a pattern, the restart on 0x0E38 after an abort, and the reserved ending 0x339C.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int KEY_W      = 14;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    localparam logic [KEY_W-1:0] KEY_STORE  = 14'h0FC0;
    localparam logic [KEY_W-1:0] KEY_RECALL = 14'h0C63;

    // Shared prefix; order is behaviour
    function automatic logic [KEY_W-1:0] prefix_key(input int idx);
        case (idx)
            0:       return 14'h0E38;
            1:       return 14'h31C7;
            2:       return 14'h03E0;
            3:       return 14'h3C1F;
            4:       return 14'h303F;
            default: return '0;
        endcase
    endfunction

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        ACC_IDLE  = 3'd0,  // no strobe
        ACC_HOLD  = 3'd1,  // busy: force idle
        ACC_WRITE = 3'd2,  // write: abort
        ACC_STEP  = 3'd3,  // enable-clocked read
        ACC_SKIP  = 3'd4   // read not enable-clocked
    } acc_e;

    typedef struct packed {
        logic next;    // key equals expected prefix entry
        logic first;   // key equals first prefix entry
        logic store;   // key equals store ending
        logic recall;  // key equals recall ending
    } hit_t;

    function automatic acc_e classify(input logic valid, input logic write,
                                      input logic ce, input logic busy);
        if (busy)       return ACC_HOLD;
        if (!valid)     return ACC_IDLE;
        if (write)      return ACC_WRITE;
        if (ce)         return ACC_STEP;
        return ACC_SKIP;
    endfunction

endpackage

// File: rtl/nvseq_match.sv
module nvseq_match
    import nvseq_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  logic [KEY_W-1:0]  key_i,
    output hit_t              hit_o
);
    logic [PREFIX_LEN-1:0] eq;

    genvar g;
    generate
        for (g = 0; g < PREFIX_LEN; g++) begin : g_cmp
            assign eq[g] = (key_i == prefix_key(g));
        end
    endgenerate

    always_comb begin
        hit_o        = '0;
        hit_o.first  = eq[0];
        hit_o.store  = (key_i == KEY_STORE);
        hit_o.recall = (key_i == KEY_RECALL);
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (step_i == STEP_W'(i)) hit_o.next = eq[i];
        end
    end
endmodule

// File: rtl/nvseq_tracker.sv
module nvseq_tracker
    import nvseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  acc_e              kind_i,
    input  hit_t              hit_i,
    output logic [STEP_W-1:0] step_o,
    output cmd_e              cmd_o
);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);
    localparam logic [STEP_W-1:0] ONE  = STEP_W'(1);

    logic [STEP_W-1:0] step_q, step_n;

    always_comb begin
        step_n = step_q;
        cmd_o  = CMD_NONE;
        case (kind_i)
            ACC_HOLD, ACC_WRITE: step_n = '0;
            ACC_STEP: begin
                if (step_q == LAST) begin
                    if (hit_i.store)       cmd_o = CMD_STORE;
                    else if (hit_i.recall) cmd_o = CMD_RECALL;
                    step_n = (cmd_o == CMD_NONE && hit_i.first) ? ONE : '0;
                end else if (hit_i.next) begin
                    step_n = step_q + ONE;
                end else begin
                    step_n = hit_i.first ? ONE : '0;
                end
            end
            default: step_n = step_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_n;
    end

    assign step_o = step_q;

    // R11: busy leaves the detector idle
    a_r11_busy_idle: assert property (@(posedge clk) disable iff (rst)
        kind_i == ACC_HOLD |=> step_q == '0);
    // R5: write aborts
    a_r5_write_abort: assert property (@(posedge clk) disable iff (rst)
        kind_i == ACC_WRITE |=> step_q == '0);
    // R10: skipped and empty cycles keep progress
    a_r10_skip_hold: assert property (@(posedge clk) disable iff (rst)
        (kind_i == ACC_SKIP || kind_i == ACC_IDLE) |=> $stable(step_q));
    // R2: progress moves one step at a time or restarts
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        step_q != $past(step_q) |->
            (step_q == $past(step_q) + ONE || step_q == '0 || step_q == ONE));
    a_r2_step_range: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST);
endmodule

// File: rtl/nvseq_pulse.sv
module nvseq_pulse
    import nvseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    output logic store_o,
    output logic recall_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            store_o  <= 1'b0;
            recall_o <= 1'b0;
        end else begin
            store_o  <= (cmd_i == CMD_STORE);
            recall_o <= (cmd_i == CMD_RECALL);
        end
    end

    // R12: never both
    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_o, recall_o}));
    // R2: store pulse lasts one cycle
    a_r2_store_single: assert property (@(posedge clk) disable iff (rst)
        store_o |=> !store_o);
    // R3: recall pulse lasts one cycle
    a_r3_recall_single: assert property (@(posedge clk) disable iff (rst)
        recall_o |=> !recall_o);
endmodule

// File: rtl/nvseq_detector.sv
module nvseq_detector
    import nvseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              acc_write_i,
    input  logic              acc_ce_i,
    input  logic              acc_oe_i,
    output logic              store_req_o,
    output logic              recall_req_o
);
    localparam int UPPER_W = ADDR_W - KEY_W;

    acc_e              kind;
    hit_t              hit;
    cmd_e              cmd;
    logic [STEP_W-1:0] step;
    logic [KEY_W-1:0]  key;
    logic              unused_ign;

    assign kind = classify(acc_valid_i, acc_write_i, acc_ce_i, busy_i);
    assign key  = acc_addr_i[KEY_W-1:0];

    generate
        if (UPPER_W > 0) begin : g_upper
            assign unused_ign = ^{acc_oe_i, acc_addr_i[ADDR_W-1:KEY_W]};
        end else begin : g_flat
            assign unused_ign = acc_oe_i;
        end
    endgenerate

    nvseq_match u_match (
        .step_i (step),
        .key_i  (key),
        .hit_o  (hit)
    );

    nvseq_tracker u_track (
        .clk    (clk),
        .rst    (rst),
        .kind_i (kind),
        .hit_i  (hit),
        .step_o (step),
        .cmd_o  (cmd)
    );

    nvseq_pulse u_pulse (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .store_o  (store_req_o),
        .recall_o (recall_req_o)
    );

    // R11/R5/R10: a request follows only an enable-clocked read while not busy
    a_r11_req_source: assert property (@(posedge clk) disable iff (rst)
        (store_req_o || recall_req_o) |->
            $past(acc_valid_i && !acc_write_i && acc_ce_i && !busy_i));
    // R2: store follows a read at the store ending
    a_r2_store_key: assert property (@(posedge clk) disable iff (rst)
        store_req_o |-> $past(acc_addr_i[KEY_W-1:0]) == KEY_STORE);
    // R3: recall follows a read at the recall ending
    a_r3_recall_key: assert property (@(posedge clk) disable iff (rst)
        recall_req_o |-> $past(acc_addr_i[KEY_W-1:0]) == KEY_RECALL);
endmodule

// File: tb/sim_nvseq_detector.sv
`timescale 1ns/1ps
module sim_nvseq_detector;
    logic        clk = 1'b0;
    logic        rst;
    logic        busy_i, acc_valid_i, acc_write_i, acc_ce_i, acc_oe_i;
    logic [14:0] acc_addr_i;
    logic        store_req_o, recall_req_o;

    int vec = 0;
    int miss = 0;
    int hist[$];
    bit exp_st, exp_rc;
    int pfx[5] = '{32'h0E38, 32'h31C7, 32'h03E0, 32'h3C1F, 32'h303F};

    always #2.5 clk = ~clk;

    nvseq_detector u0 (
        .clk(clk), .rst(rst), .busy_i(busy_i), .acc_valid_i(acc_valid_i),
        .acc_addr_i(acc_addr_i), .acc_write_i(acc_write_i), .acc_ce_i(acc_ce_i),
        .acc_oe_i(acc_oe_i), .store_req_o(store_req_o), .recall_req_o(recall_req_o)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        report();
        $finish;
    end

    // reference model: queue of accepted keys
    task automatic model(bit valid, int addr, bit wr, bit ce, bit busy);
        int k = addr & 32'h3FFF;
        exp_st = 0; exp_rc = 0;
        if (busy) begin hist.delete(); return; end
        if (!valid) return;
        if (wr) begin hist.delete(); return; end
        if (!ce) return;
        if (hist.size() == 5) begin
            if (k == 32'h0FC0) exp_st = 1;
            else if (k == 32'h0C63) exp_rc = 1;
            hist.delete();
            if (!exp_st && !exp_rc && k == pfx[0]) hist.push_back(k);
        end else if (k == pfx[hist.size()]) begin
            hist.push_back(k);
        end else begin
            hist.delete();
            if (k == pfx[0]) hist.push_back(k);
        end
    endtask

    task automatic cyc(bit valid, int addr, bit wr, bit ce, bit oe, bit busy, string tag);
        acc_valid_i = valid; acc_addr_i = addr[14:0]; acc_write_i = wr;
        acc_ce_i = ce; acc_oe_i = oe; busy_i = busy;
        model(valid, addr, wr, ce, busy);
        @(negedge clk);
        vec++;
        if (store_req_o !== exp_st || recall_req_o !== exp_rc) begin
            miss++;
            $display("FAIL %s: actual st=%b rc=%b expected st=%b rc=%b",
                     tag, store_req_o, recall_req_o, exp_st, exp_rc);
        end
        acc_valid_i = 0;
    endtask

    task automatic rd(int addr, string tag);
        cyc(1, addr, 0, 1, 1, 0, tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic pattern(int last, int hi, string tag);
        for (int i = 0; i < 5; i++) rd(pfx[i] | hi, tag);
        rd(last | hi, tag);
        idle(tag);
    endtask

    initial begin
        rst = 1; busy_i = 0; acc_valid_i = 0; acc_addr_i = '0;
        acc_write_i = 0; acc_ce_i = 0; acc_oe_i = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        vec++;
        if (store_req_o !== 0 || recall_req_o !== 0) begin
            miss++;
            $display("FAIL R1: actual st=%b rc=%b expected 0 0", store_req_o, recall_req_o);
        end
        idle("R1");

        pattern(32'h0FC0, 0, "R2 store");
        pattern(32'h0C63, 0, "R3 recall");
        pattern(32'h0FC0, 32'h4000, "R4 bit14 store");
        pattern(32'h0C63, 32'h4000, "R4 bit14 recall");

        // R9: output enable varies
        for (int i = 0; i < 5; i++) cyc(1, pfx[i], 0, 1, i[0], 0, "R9 oe");
        cyc(1, 32'h0FC0, 0, 1, 0, 0, "R9 oe");
        idle("R9");

        // R5: write at matching key mid-pattern
        rd(pfx[0], "R5"); rd(pfx[1], "R5");
        cyc(1, pfx[2], 1, 1, 1, 0, "R5 write");
        rd(pfx[3], "R5"); rd(pfx[4], "R5"); rd(32'h0FC0, "R5 no store");
        idle("R5");

        // R6: mismatch and reserved ending
        rd(pfx[0], "R6"); rd(pfx[1], "R6"); rd(32'h1234, "R6 mismatch");
        rd(pfx[2], "R6"); rd(pfx[3], "R6"); rd(pfx[4], "R6"); rd(32'h0FC0, "R6 none");
        pattern(32'h339C, 0, "R6 reserved");

        // R7: repeated key
        rd(pfx[0], "R7"); rd(pfx[1], "R7"); rd(pfx[1], "R7 repeat");
        rd(pfx[2], "R7"); rd(pfx[3], "R7"); rd(pfx[4], "R7"); rd(32'h0C63, "R7 none");
        idle("R7");

        // R8: restart on first key after abort
        rd(pfx[0], "R8"); rd(pfx[1], "R8"); rd(pfx[0], "R8 restart");
        for (int i = 1; i < 5; i++) rd(pfx[i], "R8");
        rd(32'h0FC0, "R8 store");
        idle("R8");

        // R10: gaps and reads not clocked by enable
        for (int i = 0; i < 5; i++) begin
            rd(pfx[i], "R10");
            idle("R10 gap");
            cyc(1, 32'h7777, 0, 0, 1, 0, "R10 skip");
        end
        rd(32'h0C63, "R10 recall");
        idle("R10");

        // R11: busy mid-pattern discards progress
        rd(pfx[0], "R11"); rd(pfx[1], "R11"); rd(pfx[2], "R11");
        cyc(1, pfx[3], 0, 1, 1, 1, "R11 busy");
        rd(pfx[4], "R11"); rd(32'h0FC0, "R11 none");
        // R11: full pattern while busy
        for (int i = 0; i < 5; i++) cyc(1, pfx[i], 0, 1, 1, 1, "R11 busy seq");
        cyc(1, 32'h0FC0, 0, 1, 1, 1, "R11 busy end");
        idle("R11");

        // R12: alternate commands back to back
        pattern(32'h0FC0, 0, "R12");
        pattern(32'h0C63, 0, "R12");

        report();
        $finish;
    end
endmodule